// File: doc/BRIEF.md
# Direct-Mapped Data Cache with Selectable Write Policy

This block is a direct-mapped data cache. It sits between a CPU port that issues word loads and stores and a slower memory port. The storage is 1 KB, split into 32 lines of 32 bytes. Each line keeps a valid bit, a 22-bit tag and eight 32-bit data words. Loads that hit complete in the cycle they are presented. Loads that miss fetch the whole line and then complete.

A compile-time parameter, `WRITE_BACK`, chooses how stores are handled.

- With the value 0, stores are write-through and do not allocate on a miss. Each store is posted into a four-entry buffer that drains to memory in the background.
- With the value 1, stores are write-back and allocate on a miss. A store only marks the line dirty. A dirty line is written out in full when a different line replaces it.

The CPU holds `cpu_req`, `cpu_we`, `cpu_addr` and `cpu_wdata` steady until it sees `cpu_ready`, and then drops or changes them after that clock edge. The memory side moves one 32-bit word for each `mem_ack`. Bursts keep `mem_req` high while the word address steps up.

Top module: `dmc_cache`

## Requirements
- R1: An address splits into a word select in bits 4:2, a line index in bits 9:5 and a tag in bits 31:10. A load hits only when the indexed line is valid and its stored tag equals bits 31:10. Data is then returned from the word chosen by bits 4:2.
- R2: Reset clears every valid bit and every dirty bit, so the first load to any address after reset is a miss.
- R3: A load miss reads the eight words of the enclosing 32-byte line from memory, lowest address first, starting at the line base. `cpu_ready` then rises with the requested word on `cpu_rdata`.
- R4: A load hit raises `cpu_ready` in the same cycle as the request and makes no memory access.
- R5: A line fetched for an address overwrites whatever line was held at that index. A later load of the displaced address misses.
- R6: In write-through mode (`WRITE_BACK`=0), a store that hits updates the cached word. The store completes in its request cycle unless the buffer is full. It later appears on memory as a single write (`mem_we`=1) carrying the CPU address and data.
- R7: In write-through mode, a store that misses allocates no line. Its data reaches memory only, and a following load of that address misses.
- R8: In write-through mode, the buffer holds four stores. A fifth store while four are pending waits until one has been written. Memory receives the stores in issue order.
- R9: In write-through mode, a load miss issues no memory read until every buffered store has been written to memory.
- R10: In write-back mode (`WRITE_BACK`=1), a store that hits completes in its request cycle. It updates only the cached word, makes no memory access and marks the line dirty.
- R11: In write-back mode, a store that misses first fetches the line as in R3 and then writes the word into it.
- R12: In write-back mode, replacing a dirty line first writes its eight words to memory, lowest address first, before the new line is read. Replacing a clean line writes nothing.
- R13: While `mem_req` is high and `mem_ack` is low, `mem_addr`, `mem_we` and `mem_wdata` stay unchanged. Each `mem_ack` cycle transfers exactly one word.
- R14: `cpu_ready` is high only while `cpu_req` is high. It is high for one cycle per completed access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release synchronously |
| cpu_req | input | 1 | CPU access request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address of the access |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid while `cpu_ready` is high on a load |
| cpu_ready | output | 1 | Access completes at this clock edge |
| mem_req | output | 1 | Memory word transfer request |
| mem_we | output | 1 | 1 = write word to memory, 0 = read word |
| mem_addr | output | 32 | Byte address of the current word |
| mem_wdata | output | 32 | Word written to memory |
| mem_rdata | input | 32 | Word read from memory, valid with `mem_ack` |
| mem_ack | input | 1 | Current word transferred at this clock edge |

## Verification
The bench builds two copies of the cache side by side. One uses `WRITE_BACK`=0 against a memory that answers after six idle cycles. The other uses `WRITE_BACK`=1 against a memory that answers after two.

The slow memory keeps posted stores pending long enough for a burst of stores to fill the buffer. This makes the full-buffer stall and the ordering of drain before fill observable.

The fast memory lets dirty evictions, clean replacements and write allocation be checked word by word. The memory's write and read logs are compared against addresses and patterns that the bench computes from the address.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_EVICT = 2'd1,
    ST_FILL  = 2'd2
  } dmc_state_e;

endpackage

// File: rtl/dmc_wbuf.sv
module dmc_wbuf #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [ADDR_W-1:0] head_addr,
  output logic [DATA_W-1:0] head_data,
  output logic              empty,
  output logic              full
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [PTR_W-1:0]  rd_q, rd_d, wr_q, wr_d;
  logic [PTR_W:0]    cnt_q, cnt_d;

  assign empty     = (cnt_q == '0);
  assign full      = (cnt_q == (PTR_W+1)'(DEPTH));
  assign head_addr = addr_q[rd_q];
  assign head_data = data_q[rd_q];

  always_comb begin
    rd_d  = rd_q;
    wr_d  = wr_q;
    cnt_d = cnt_q;
    if (push) begin
      wr_d = (wr_q == PTR_W'(DEPTH-1)) ? '0 : wr_q + 1'b1;
    end
    if (pop) begin
      rd_d = (rd_q == PTR_W'(DEPTH-1)) ? '0 : rd_q + 1'b1;
    end
    case ({push, pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      addr_q[wr_q] <= push_addr;
      data_q[wr_q] <= push_data;
    end
  end

  AST_WBUF_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full); // R8
  AST_WBUF_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty); // R8

endmodule

// File: rtl/dmc_lines.sv
module dmc_lines #(
  parameter int LINES  = 32,
  parameter int WORDS  = 8,
  parameter int TAG_W  = 22,
  parameter int DATA_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [$clog2(LINES)-1:0] idx,
  input  logic [$clog2(WORDS)-1:0] rd_word,
  input  logic                     wr_en,
  input  logic [$clog2(WORDS)-1:0] wr_word,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic                     fill_done,
  input  logic [TAG_W-1:0]         fill_tag,
  input  logic                     dirty_set,
  output logic                     ln_valid,
  output logic                     ln_dirty,
  output logic [TAG_W-1:0]         ln_tag,
  output logic [DATA_W-1:0]        ln_data
);

  localparam int IDX_W  = $clog2(LINES);
  localparam int WSEL_W = $clog2(WORDS);
  localparam int CELLS  = LINES * WORDS;

  logic [LINES-1:0]  valid_q, valid_d;
  logic [LINES-1:0]  dirty_q, dirty_d;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [CELLS];

  assign ln_valid = valid_q[idx];
  assign ln_dirty = dirty_q[idx];
  assign ln_tag   = tag_q[idx];
  assign ln_data  = data_q[{idx, rd_word}];

  always_comb begin
    valid_d = valid_q;
    dirty_d = dirty_q;
    if (fill_done) begin
      valid_d[idx] = 1'b1;
      dirty_d[idx] = 1'b0;
    end
    if (dirty_set) begin
      dirty_d[idx] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else begin
      valid_q <= valid_d;
      dirty_q <= dirty_d;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_done) begin
      tag_q[idx] <= fill_tag;
    end
    if (wr_en) begin
      data_q[(IDX_W+WSEL_W)'({idx, wr_word})] <= wr_data;
    end
  end

  AST_DIRTY_ON_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    dirty_set |-> valid_q[idx]); // R10

endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
  import dmc_pkg::*;
#(
  parameter bit WRITE_BACK = 1'b0,
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int IDX_W      = 5,
  parameter int WSEL_W     = 3,
  parameter int TAG_W      = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack,
  output logic [IDX_W-1:0]  ln_idx,
  output logic [WSEL_W-1:0] ln_rd_word,
  output logic              ln_wr_en,
  output logic [WSEL_W-1:0] ln_wr_word,
  output logic [DATA_W-1:0] ln_wr_data,
  output logic              ln_fill_done,
  output logic [TAG_W-1:0]  ln_fill_tag,
  output logic              ln_dirty_set,
  input  logic              ln_valid,
  input  logic              ln_dirty,
  input  logic [TAG_W-1:0]  ln_tag,
  input  logic [DATA_W-1:0] ln_data,
  output logic              wb_push,
  output logic              wb_pop,
  input  logic              wb_empty,
  input  logic              wb_full,
  input  logic [ADDR_W-1:0] wb_head_addr,
  input  logic [DATA_W-1:0] wb_head_data
);

  localparam int BYTE_W = $clog2(DATA_W / 8);
  localparam int OFF_W  = WSEL_W + BYTE_W;
  localparam logic [WSEL_W-1:0] LAST_WORD = '1;

  dmc_state_e        state_q, state_d;
  logic [WSEL_W-1:0] cnt_q, cnt_d;
  logic [TAG_W-1:0]  req_tag;
  logic [WSEL_W-1:0] req_word;
  logic              hit;

  assign ln_idx      = cpu_addr[OFF_W +: IDX_W];
  assign req_tag     = cpu_addr[ADDR_W-1 -: TAG_W];
  assign req_word    = cpu_addr[BYTE_W +: WSEL_W];
  assign ln_fill_tag = req_tag;
  assign hit         = ln_valid && (ln_tag == req_tag);

  always_comb begin
    state_d      = state_q;
    cnt_d        = cnt_q;
    cpu_ready    = 1'b0;
    mem_req      = 1'b0;
    mem_we       = 1'b0;
    mem_addr     = '0;
    mem_wdata    = '0;
    ln_rd_word   = req_word;
    ln_wr_en     = 1'b0;
    ln_wr_word   = req_word;
    ln_wr_data   = cpu_wdata;
    ln_fill_done = 1'b0;
    ln_dirty_set = 1'b0;
    wb_push      = 1'b0;
    wb_pop       = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (!WRITE_BACK && !wb_empty) begin
          mem_req   = 1'b1;
          mem_we    = 1'b1;
          mem_addr  = wb_head_addr;
          mem_wdata = wb_head_data;
          wb_pop    = mem_ack;
        end
        if (cpu_req) begin
          if (!cpu_we) begin
            if (hit) begin
              cpu_ready = 1'b1;
            end else if (WRITE_BACK && ln_valid && ln_dirty) begin
              state_d = ST_EVICT;
            end else if (wb_empty) begin
              state_d = ST_FILL;
            end
          end else if (WRITE_BACK) begin
            if (hit) begin
              cpu_ready    = 1'b1;
              ln_wr_en     = 1'b1;
              ln_dirty_set = 1'b1;
            end else if (ln_valid && ln_dirty) begin
              state_d = ST_EVICT;
            end else begin
              state_d = ST_FILL;
            end
          end else if (!wb_full) begin
            cpu_ready = 1'b1;
            wb_push   = 1'b1;
            ln_wr_en  = hit;
          end
        end
      end
      ST_EVICT: begin
        mem_req    = 1'b1;
        mem_we     = 1'b1;
        ln_rd_word = cnt_q;
        mem_addr   = {ln_tag, ln_idx, cnt_q, BYTE_W'(0)};
        mem_wdata  = ln_data;
        if (mem_ack) begin
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == LAST_WORD) begin
            state_d = ST_FILL;
          end
        end
      end
      ST_FILL: begin
        mem_req  = 1'b1;
        mem_addr = {req_tag, ln_idx, cnt_q, BYTE_W'(0)};
        if (mem_ack) begin
          ln_wr_en   = 1'b1;
          ln_wr_word = cnt_q;
          ln_wr_data = mem_rdata;
          cnt_d      = cnt_q + 1'b1;
          if (cnt_q == LAST_WORD) begin
            ln_fill_done = 1'b1;
            state_d      = ST_IDLE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  AST_READY_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> cpu_req); // R14
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R13
  AST_FILL_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> wb_empty); // R9
  AST_WB_HIT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (WRITE_BACK && cpu_ready && cpu_we) |-> !mem_req); // R10

endmodule

// File: rtl/dmc_cache.sv
module dmc_cache #(
  parameter bit WRITE_BACK  = 1'b0,
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int LINE_BYTES  = 32,
  parameter int CACHE_BYTES = 1024,
  parameter int WBUF_DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack
);

  localparam int WORDS  = LINE_BYTES / (DATA_W / 8);
  localparam int LINES  = CACHE_BYTES / LINE_BYTES;
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int IDX_W  = $clog2(LINES);
  localparam int WSEL_W = $clog2(WORDS);
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;

  logic [IDX_W-1:0]  ln_idx;
  logic [WSEL_W-1:0] ln_rd_word, ln_wr_word;
  logic              ln_wr_en, ln_fill_done, ln_dirty_set;
  logic [DATA_W-1:0] ln_wr_data, ln_data;
  logic [TAG_W-1:0]  ln_fill_tag, ln_tag;
  logic              ln_valid, ln_dirty;
  logic              wb_push, wb_pop, wb_empty, wb_full;
  logic [ADDR_W-1:0] wb_head_addr;
  logic [DATA_W-1:0] wb_head_data;

  assign cpu_rdata = ln_data;

  dmc_lines #(
    .LINES (LINES),
    .WORDS (WORDS),
    .TAG_W (TAG_W),
    .DATA_W(DATA_W)
  ) u_lines (
    .clk      (clk),
    .rst_n    (rst_n),
    .idx      (ln_idx),
    .rd_word  (ln_rd_word),
    .wr_en    (ln_wr_en),
    .wr_word  (ln_wr_word),
    .wr_data  (ln_wr_data),
    .fill_done(ln_fill_done),
    .fill_tag (ln_fill_tag),
    .dirty_set(ln_dirty_set),
    .ln_valid (ln_valid),
    .ln_dirty (ln_dirty),
    .ln_tag   (ln_tag),
    .ln_data  (ln_data)
  );

  generate
    if (!WRITE_BACK) begin : g_wbuf
      dmc_wbuf #(
        .DEPTH (WBUF_DEPTH),
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
      ) u_wbuf (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (wb_push),
        .push_addr(cpu_addr),
        .push_data(cpu_wdata),
        .pop      (wb_pop),
        .head_addr(wb_head_addr),
        .head_data(wb_head_data),
        .empty    (wb_empty),
        .full     (wb_full)
      );
    end else begin : g_nobuf
      assign wb_empty     = 1'b1;
      assign wb_full      = 1'b0;
      assign wb_head_addr = '0;
      assign wb_head_data = '0;
    end
  endgenerate

  dmc_ctrl #(
    .WRITE_BACK(WRITE_BACK),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .IDX_W     (IDX_W),
    .WSEL_W    (WSEL_W),
    .TAG_W     (TAG_W)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_req     (cpu_req),
    .cpu_we      (cpu_we),
    .cpu_addr    (cpu_addr),
    .cpu_wdata   (cpu_wdata),
    .cpu_ready   (cpu_ready),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_rdata   (mem_rdata),
    .mem_ack     (mem_ack),
    .ln_idx      (ln_idx),
    .ln_rd_word  (ln_rd_word),
    .ln_wr_en    (ln_wr_en),
    .ln_wr_word  (ln_wr_word),
    .ln_wr_data  (ln_wr_data),
    .ln_fill_done(ln_fill_done),
    .ln_fill_tag (ln_fill_tag),
    .ln_dirty_set(ln_dirty_set),
    .ln_valid    (ln_valid),
    .ln_dirty    (ln_dirty),
    .ln_tag      (ln_tag),
    .ln_data     (ln_data),
    .wb_push     (wb_push),
    .wb_pop      (wb_pop),
    .wb_empty    (wb_empty),
    .wb_full     (wb_full),
    .wb_head_addr(wb_head_addr),
    .wb_head_data(wb_head_data)
  );

endmodule

// File: tb/dmc_mem_model.sv
module dmc_mem_model #(
  parameter int LAT = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mem_req,
  input  logic        mem_we,
  input  logic [31:0] mem_addr,
  input  logic [31:0] mem_wdata,
  output logic [31:0] mem_rdata,
  output logic        mem_ack
);

  logic [31:0] store [logic [31:0]];
  int          wr_cnt = 0;
  int          rd_cnt = 0;
  int          wait_cnt = 0;
  logic [31:0] wlog_a [512];
  logic [31:0] wlog_d [512];
  logic [31:0] rlog_a [512];
  int          rlog_wc [512];

  function automatic logic [31:0] pat(input logic [31:0] a);
    return {a[31:2], 2'b00} ^ 32'hC3A5_0000;
  endfunction

  initial begin
    mem_ack   = 1'b0;
    mem_rdata = '0;
  end

  always @(negedge clk) begin
    logic [31:0] k;
    k = {mem_addr[31:2], 2'b00};
    if (!rst_n) begin
      mem_ack  = 1'b0;
      wait_cnt = 0;
    end else if (mem_ack) begin
      mem_ack = 1'b0;
    end else if (mem_req) begin
      if (wait_cnt >= LAT) begin
        wait_cnt = 0;
        mem_ack  = 1'b1;
        if (mem_we) begin
          store[k] = mem_wdata;
          wlog_a[wr_cnt % 512] = mem_addr;
          wlog_d[wr_cnt % 512] = mem_wdata;
          wr_cnt++;
        end else begin
          mem_rdata = store.exists(k) ? store[k] : pat(k);
          rlog_a[rd_cnt % 512]  = mem_addr;
          rlog_wc[rd_cnt % 512] = wr_cnt;
          rd_cnt++;
        end
      end else begin
        wait_cnt++;
      end
    end else begin
      wait_cnt = 0;
    end
  end

endmodule

// File: tb/dmc_cache_test.sv
module dmc_cache_test;

  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic        c_req   [2];
  logic        c_we    [2];
  logic [31:0] c_addr  [2];
  logic [31:0] c_wdata [2];
  logic [31:0] c_rdata [2];
  logic        c_ready [2];
  logic        m_req   [2];
  logic        m_we    [2];
  logic [31:0] m_addr  [2];
  logic [31:0] m_wdata [2];
  logic [31:0] m_rdata [2];
  logic        m_ack   [2];

  int checks = 0;
  int errors = 0;
  bit ended  = 1'b0;

  dmc_cache #(.WRITE_BACK(1'b0)) uut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(c_req[0]), .cpu_we(c_we[0]), .cpu_addr(c_addr[0]), .cpu_wdata(c_wdata[0]),
    .cpu_rdata(c_rdata[0]), .cpu_ready(c_ready[0]),
    .mem_req(m_req[0]), .mem_we(m_we[0]), .mem_addr(m_addr[0]), .mem_wdata(m_wdata[0]),
    .mem_rdata(m_rdata[0]), .mem_ack(m_ack[0])
  );
  dmc_mem_model #(.LAT(6)) m0 (
    .clk(clk), .rst_n(rst_n), .mem_req(m_req[0]), .mem_we(m_we[0]), .mem_addr(m_addr[0]),
    .mem_wdata(m_wdata[0]), .mem_rdata(m_rdata[0]), .mem_ack(m_ack[0])
  );

  dmc_cache #(.WRITE_BACK(1'b1)) uut_wb (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(c_req[1]), .cpu_we(c_we[1]), .cpu_addr(c_addr[1]), .cpu_wdata(c_wdata[1]),
    .cpu_rdata(c_rdata[1]), .cpu_ready(c_ready[1]),
    .mem_req(m_req[1]), .mem_we(m_we[1]), .mem_addr(m_addr[1]), .mem_wdata(m_wdata[1]),
    .mem_rdata(m_rdata[1]), .mem_ack(m_ack[1])
  );
  dmc_mem_model #(.LAT(2)) m1 (
    .clk(clk), .rst_n(rst_n), .mem_req(m_req[1]), .mem_we(m_we[1]), .mem_addr(m_addr[1]),
    .mem_wdata(m_wdata[1]), .mem_rdata(m_rdata[1]), .mem_ack(m_ack[1])
  );

  function automatic logic [31:0] pat(input logic [31:0] a);
    return {a[31:2], 2'b00} ^ 32'hC3A5_0000;
  endfunction

  function automatic int wrc(input int u);
    return (u != 0) ? m1.wr_cnt : m0.wr_cnt;
  endfunction
  function automatic int rdc(input int u);
    return (u != 0) ? m1.rd_cnt : m0.rd_cnt;
  endfunction
  function automatic logic [31:0] wla(input int u, input int i);
    return (u != 0) ? m1.wlog_a[i % 512] : m0.wlog_a[i % 512];
  endfunction
  function automatic logic [31:0] wld(input int u, input int i);
    return (u != 0) ? m1.wlog_d[i % 512] : m0.wlog_d[i % 512];
  endfunction
  function automatic logic [31:0] rla(input int u, input int i);
    return (u != 0) ? m1.rlog_a[i % 512] : m0.rlog_a[i % 512];
  endfunction
  function automatic int rlw(input int u, input int i);
    return (u != 0) ? m1.rlog_wc[i % 512] : m0.rlog_wc[i % 512];
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=0x%08h exp=0x%08h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic acc(input int u, input bit we, input logic [31:0] a, input logic [31:0] d,
                     output logic [31:0] rd, output int cyc);
    @(negedge clk);
    c_req[u] = 1'b1; c_we[u] = we; c_addr[u] = a; c_wdata[u] = d;
    cyc = 0;
    #1;
    while (!c_ready[u] && cyc < 3000) begin
      @(negedge clk); #1; cyc++;
    end
    rd = c_rdata[u];
    if (cyc >= 3000) begin
      checks++; errors++;
      $display("FAIL R14 access never completed act=%0d exp<3000", cyc);
    end
    @(posedge clk); #1;
    c_req[u] = 1'b0; c_we[u] = 1'b0;
  endtask

  task automatic wait_writes(input int u, input int target);
    for (int i = 0; i < 1000 && wrc(u) < target; i++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 150000);
    checks++; errors++;
    $display("FAIL R14 watchdog expired act=1 exp=0");
    summary();
  end

  initial begin
    logic [31:0] rd;
    int cyc, r0, w0;
    logic [31:0] a_x, c_x, b_x, d_x, e_x, x_x, y_x, z_x;
    bit ok;
    for (int u = 0; u < 2; u++) begin
      c_req[u] = 0; c_we[u] = 0; c_addr[u] = 0; c_wdata[u] = 0;
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state, R14
    chk("R14", "ready idle after reset wt", {31'd0, c_ready[0]}, 32'd0);
    chk("R14", "ready idle after reset wb", {31'd0, c_ready[1]}, 32'd0);
    chk("R13", "no mem req after reset", {31'd0, m_req[0] | m_req[1]}, 32'd0);

    // ---------------- write-through copy ----------------
    a_x = 32'h0000_1048;   // index 2, word 2
    c_x = a_x + 32'h400;   // same index, other tag
    r0 = rdc(0);
    acc(0, 1'b0, a_x, '0, rd, cyc);
    chk("R2", "first load misses", {31'd0, cyc > 0}, 32'd1);
    chk("R3", "fill word count", r0 + 8, rdc(0));
    ok = 1'b1;
    for (int k = 0; k < 8; k++) if (rla(0, r0 + k) != 32'h0000_1040 + 32'(4*k)) ok = 1'b0;
    chk("R3", "fill ascending from line base (R13 one word per ack)", {31'd0, ok}, 32'd1);
    chk("R1", "miss data from word select", rd, pat(a_x));

    r0 = rdc(0);
    acc(0, 1'b0, a_x + 4, '0, rd, cyc);
    chk("R4", "hit is zero wait", cyc, 0);
    chk("R4", "hit no memory reads", rdc(0), r0);
    chk("R1", "hit word 3", rd, pat(a_x + 4));
    #1;
    chk("R14", "ready drops after access", {31'd0, c_ready[0]}, 32'd0);

    acc(0, 1'b0, c_x, '0, rd, cyc);
    chk("R5", "conflicting tag misses", {31'd0, cyc > 0}, 32'd1);
    chk("R1", "conflicting data", rd, pat(c_x));
    acc(0, 1'b0, a_x, '0, rd, cyc);
    chk("R5", "displaced line misses", {31'd0, cyc > 0}, 32'd1);

    w0 = wrc(0);
    acc(0, 1'b1, a_x, 32'hDEAD_0001, rd, cyc);
    chk("R6", "store hit zero wait", cyc, 0);
    acc(0, 1'b0, a_x, '0, rd, cyc);
    chk("R6", "store hit updates line", rd, 32'hDEAD_0001);
    chk("R6", "reload after store hits", cyc, 0);
    wait_writes(0, w0 + 1);
    chk("R6", "posted write count", wrc(0), w0 + 1);
    chk("R6", "posted write addr", wla(0, w0), a_x);
    chk("R6", "posted write data", wld(0, w0), 32'hDEAD_0001);

    b_x = 32'h0000_2104;
    w0 = wrc(0);
    acc(0, 1'b1, b_x, 32'h0BAD_F00D, rd, cyc);
    chk("R7", "store miss zero wait", cyc, 0);
    wait_writes(0, w0 + 1);
    r0 = rdc(0);
    acc(0, 1'b0, b_x, '0, rd, cyc);
    chk("R7", "no allocate on store miss", rdc(0), r0 + 8);
    chk("R7", "memory holds store", rd, 32'h0BAD_F00D);

    d_x = 32'h0000_3000;
    w0 = wrc(0);
    for (int k = 0; k < 5; k++) begin
      acc(0, 1'b1, d_x + 32'(4*k), 32'h100 + 32'(k), rd, cyc);
      if (k < 4) chk("R8", "store into free buffer slot", cyc, 0);
      else chk("R8", "fifth store stalls", {31'd0, cyc > 0}, 32'd1);
    end
    e_x = 32'h0000_5000;
    r0 = rdc(0);
    acc(0, 1'b0, e_x, '0, rd, cyc);
    chk("R9", "fill waits for drain", rlw(0, r0), w0 + 5);
    chk("R9", "load after drain data", rd, pat(e_x));
    ok = 1'b1;
    for (int k = 0; k < 5; k++) begin
      if (wla(0, w0 + k) != d_x + 32'(4*k)) ok = 1'b0;
      if (wld(0, w0 + k) != 32'h100 + 32'(k)) ok = 1'b0;
    end
    chk("R8", "stores drain in order", {31'd0, ok}, 32'd1);

    // ---------------- write-back copy ----------------
    x_x = 32'h0000_4064;   // index 3, word 1
    y_x = x_x + 32'h800;
    acc(1, 1'b0, x_x, '0, rd, cyc);
    chk("R3", "wb load miss data", rd, pat(x_x));
    w0 = wrc(1);
    acc(1, 1'b1, x_x, 32'hBEEF_0002, rd, cyc);
    chk("R10", "wb store hit zero wait", cyc, 0);
    repeat (40) @(negedge clk);
    chk("R10", "wb store hit no memory write", wrc(1), w0);
    acc(1, 1'b0, x_x, '0, rd, cyc);
    chk("R10", "wb store visible in cache", rd, 32'hBEEF_0002);

    r0 = rdc(1);
    acc(1, 1'b0, y_x, '0, rd, cyc);
    chk("R12", "dirty eviction writes line", wrc(1), w0 + 8);
    ok = 1'b1;
    for (int k = 0; k < 8; k++) begin
      if (wla(1, w0 + k) != 32'h0000_4060 + 32'(4*k)) ok = 1'b0;
      if (wld(1, w0 + k) != ((k == 1) ? 32'hBEEF_0002 : pat(32'h0000_4060 + 32'(4*k)))) ok = 1'b0;
    end
    chk("R12", "eviction addresses and data", {31'd0, ok}, 32'd1);
    chk("R12", "eviction before fill", rlw(1, r0), w0 + 8);
    chk("R5", "wb new line data", rd, pat(y_x));

    w0 = wrc(1);
    acc(1, 1'b0, x_x, '0, rd, cyc);
    chk("R12", "clean replacement writes nothing", wrc(1), w0);
    chk("R12", "written back data reloaded", rd, 32'hBEEF_0002);

    z_x = 32'h0000_6108;
    r0 = rdc(1);
    acc(1, 1'b1, z_x, 32'h1234_5678, rd, cyc);
    chk("R11", "store miss fetches line", rdc(1), r0 + 8);
    chk("R11", "store miss no write", wrc(1), w0);
    acc(1, 1'b0, z_x, '0, rd, cyc);
    chk("R11", "allocated line hits", cyc, 0);
    chk("R11", "allocated word data", rd, 32'h1234_5678);
    acc(1, 1'b0, z_x + 32'h400, '0, rd, cyc);
    chk("R10", "allocated store marked dirty", wrc(1), w0 + 8);

    // ---------------- reset clears state ----------------
    pulse_reset();
    acc(1, 1'b0, z_x + 32'h400, '0, rd, cyc);
    chk("R2", "wb line invalid after reset", {31'd0, cyc > 0}, 32'd1);
    w0 = wrc(1);
    acc(1, 1'b0, z_x, '0, rd, cyc);
    chk("R2", "dirty cleared by reset", wrc(1), w0);
    acc(0, 1'b0, e_x, '0, rd, cyc);
    chk("R2", "wt line invalid after reset", {31'd0, cyc > 0}, 32'd1);

    summary();
  end

endmodule